// File: doc/BRIEF.md
# Color Palette and Subpixel Packer for Passive STN Panels

This block turns a stream of pixel indices into the nibble-wide data words that a passive STN panel shifts in. Each pixel index is 1, 2, 4 or 8 bits deep. In color modes it looks up a red, a green and a blue palette. Each palette holds sixteen 4-bit intensities. In gray modes only the green palette is used, as a remap of the gray level. Every 4-bit intensity is reduced to a single on/off subpixel bit by comparing it with a frame phase that the timing logic supplies. The resulting bits form a continuous R, G, B stream. That stream is packed most-significant-bit first into 4-bit words for a narrow panel, or into 8-bit words (upper nibble first, then lower nibble) for a wide panel. A one-cycle `shift_en` pulse marks each finished word.

A small state machine sequences the subpixels. It has three states: TAKE, GREEN and BLUE.
- TAKE accepts a pixel and emits its first bit. For a color pixel the first bit is red; in mono or gray mode it is the pixel's only bit.
- If the accepted pixel is a color pixel, the machine moves TAKE→GREEN. Otherwise it stays in TAKE.
- GREEN emits the held green bit and always moves GREEN→BLUE.
- BLUE emits the held blue bit and always moves BLUE→TAKE.
- The input is ready only in TAKE.

Top module: `lcd_color_packer`

## Requirements
- R1: After reset, `ud` and `ld` are 0, `shift_en` is 0, `pix_ready` is 1, and palette entry k of every channel holds k.
- R2: In 1 bpp mode (`bpp_sel`=0) with a 4-bit bus (`wide_bus`=0), successive pixels fill `ud[3]`, `ud[2]`, `ud[1]`, `ud[0]` in that order, and each group of 4 pixels yields one word.
- R3: With `wide_bus`=1, successive bits fill `ud[3]` down to `ud[0]` and then `ld[3]` down to `ld[0]`, so each word takes 8 bits.
- R4: With `wide_bus`=0, `ld` stays 0.
- R5: In color mode (`color_mode`=1, `bpp_sel`≠0), each accepted pixel produces three bits in the order red, green, blue, and `pix_ready` is 0 for the two cycles that follow the accept.
- R6: In gray mode (`color_mode`=0, `bpp_sel`≠0), only the green palette decides the bit; the red and blue palettes have no effect.
- R7: The palette address is `pix_idx[1:0]` for 2 bpp (`bpp_sel`=1) and `pix_idx[3:0]` for 4 bpp (`bpp_sel`=2), zero-extended to 4 bits. The same holds for 8 bpp in gray mode (`bpp_sel`=3), which uses `pix_idx[3:0]`. Upper index bits are ignored.
- R8: In 8 bpp color mode, red uses address `pix_idx[7:5]`, green uses `pix_idx[4:2]` and blue uses `pix_idx[1:0]`, each zero-extended.
- R9: A subpixel bit is 1 exactly when its palette value is strictly greater than `frame_phase`, taken at the cycle the pixel is accepted.
- R10: When `pal_we` is 1 at a clock edge, `pal_data` is stored at `pal_addr` of the channel that `pal_sel` picks (0 red, 1 green, 2 blue), and it applies to pixels accepted after that edge. `pal_sel`=3 writes nothing.
- R11: `shift_en` is high for exactly the one cycle after the edge that pushes a word's last bit, and `ud`/`ld` change only on the edge that raises it.
- R12: In 1 bpp mode the bit is `pix_idx[0]`, whatever the values of `color_mode`, `frame_phase` and the palettes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel index valid |
| pix_ready | output | 1 | Block can accept a pixel this cycle |
| pix_idx | input | 8 | Pixel index (low bits used per depth) |
| bpp_sel | input | 2 | Depth: 0=1, 1=2, 2=4, 3=8 bits per pixel |
| color_mode | input | 1 | 1 = color (three channels), 0 = gray (green only) |
| wide_bus | input | 1 | 1 = 8-bit panel bus, 0 = 4-bit |
| frame_phase | input | 4 | Frame counter used as intensity threshold |
| pal_we | input | 1 | Palette write enable |
| pal_sel | input | 2 | Palette channel: 0 red, 1 green, 2 blue |
| pal_addr | input | 4 | Palette entry address |
| pal_data | input | 4 | Palette entry value |
| ud | output | 4 | Upper data nibble |
| ld | output | 4 | Lower data nibble (0 on a 4-bit bus) |
| shift_en | output | 1 | One-cycle strobe marking a new word on ud/ld |

## Verification
The hardest case to reach is a word boundary that falls in the middle of a pixel. In color mode on a 4-bit bus, a pixel's green and blue bits land in the next word. On an 8-bit bus, the third pixel's blue bit is left pending.

The stimulus reaches these cases with small runs of three or four pixels. Their palette values are programmed so that the red, green and blue bits differ from one another, which makes any rotation or ordering error show up in the captured words.

Gray mode is checked with an index whose upper bits disagree with its low bits. A red entry is also set to a value that would flip the output if red were consulted.

// File: rtl/lcd_color_packer_pkg.sv
package lcd_color_packer_pkg;
    typedef enum logic [1:0] {
        ST_TAKE  = 2'd0,
        ST_GREEN = 2'd1,
        ST_BLUE  = 2'd2
    } sp_state_t;

    localparam logic [1:0] DEPTH_1 = 2'd0;
    localparam logic [1:0] DEPTH_2 = 2'd1;
    localparam logic [1:0] DEPTH_4 = 2'd2;
    localparam logic [1:0] DEPTH_8 = 2'd3;

    localparam int CH_RED   = 0;
    localparam int CH_GREEN = 1;
    localparam int CH_BLUE  = 2;
    localparam int NUM_CH   = 3;
endpackage

// File: rtl/pal_bank.sv
module pal_bank #(
    parameter int ENTRIES = 16,
    parameter int VW      = 4,
    parameter int NCH     = 3,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [1:0]               sel,
    input  logic [AW-1:0]            waddr,
    input  logic [VW-1:0]            wdata,
    input  logic [NCH-1:0][AW-1:0]   raddr,
    output logic [NCH-1:0][VW-1:0]   rdata
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [VW-1:0] mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < ENTRIES; k++) begin
                    mem[k] <= VW'(k);
                end
            end else if (we && (sel == 2'(c))) begin
                mem[waddr] <= wdata;
            end
        end

        assign rdata[c] = mem[raddr[c]];
    end
endmodule

// File: rtl/subpix_fsm.sv
module subpix_fsm
    import lcd_color_packer_pkg::*;
#(
    parameter int VW = 4,
    parameter int AW = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pix_valid,
    output logic                     pix_ready,
    input  logic [7:0]               pix_idx,
    input  logic [1:0]               bpp_sel,
    input  logic                     color_mode,
    input  logic [VW-1:0]            frame_phase,
    output logic [NUM_CH-1:0][AW-1:0] raddr,
    input  logic [NUM_CH-1:0][VW-1:0] rdata,
    output logic                     push,
    output logic                     push_bit
);
    sp_state_t state, state_nx;
    logic      g_hold, b_hold;
    logic      mono, chroma, accept;
    logic      r_bit, g_bit, b_bit;

    assign mono   = (bpp_sel == DEPTH_1);
    assign chroma = color_mode && !mono;
    assign accept = (state == ST_TAKE) && pix_valid;

    // Palette address decode per depth
    always_comb begin
        raddr = '0;
        unique case (bpp_sel)
            DEPTH_2: begin
                for (int c = 0; c < NUM_CH; c++) raddr[c] = AW'(pix_idx[1:0]);
            end
            DEPTH_8: begin
                if (color_mode) begin
                    raddr[CH_RED]   = AW'(pix_idx[7:5]);
                    raddr[CH_GREEN] = AW'(pix_idx[4:2]);
                    raddr[CH_BLUE]  = AW'(pix_idx[1:0]);
                end else begin
                    for (int c = 0; c < NUM_CH; c++) raddr[c] = AW'(pix_idx[3:0]);
                end
            end
            default: begin
                for (int c = 0; c < NUM_CH; c++) raddr[c] = AW'(pix_idx[3:0]);
            end
        endcase
    end

    assign r_bit = rdata[CH_RED]   > frame_phase;
    assign g_bit = rdata[CH_GREEN] > frame_phase;
    assign b_bit = rdata[CH_BLUE]  > frame_phase;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_TAKE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_hold <= 1'b0;
            b_hold <= 1'b0;
        end else if (accept) begin
            g_hold <= g_bit;
            b_hold <= b_bit;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_TAKE:  if (accept && chroma) state_nx = ST_GREEN;
            ST_GREEN: state_nx = ST_BLUE;
            ST_BLUE:  state_nx = ST_TAKE;
            default:  state_nx = ST_TAKE;
        endcase
    end

    // Outputs
    always_comb begin
        pix_ready = 1'b0;
        push      = 1'b0;
        push_bit  = 1'b0;
        unique case (state)
            ST_TAKE: begin
                pix_ready = 1'b1;
                push      = pix_valid;
                push_bit  = mono ? pix_idx[0] : (chroma ? r_bit : g_bit);
            end
            ST_GREEN: begin
                push     = 1'b1;
                push_bit = g_hold;
            end
            ST_BLUE: begin
                push     = 1'b1;
                push_bit = b_hold;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bit_packer.sv
module bit_packer #(
    parameter int NIB = 4,
    localparam int W  = 2 * NIB,
    localparam int CW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic           push_bit,
    input  logic           wide,
    output logic [NIB-1:0] ud,
    output logic [NIB-1:0] ld,
    output logic           shift_en
);
    logic [W-2:0]  sh;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = wide ? (cnt == CW'(W - 1)) : (cnt == CW'(NIB - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            cnt      <= '0;
            ud       <= '0;
            ld       <= '0;
            shift_en <= 1'b0;
        end else begin
            shift_en <= 1'b0;
            if (push) begin
                if (last) begin
                    if (wide) begin
                        {ud, ld} <= {sh, push_bit};
                    end else begin
                        ud <= {sh[NIB-2:0], push_bit};
                        ld <= '0;
                    end
                    cnt      <= '0;
                    shift_en <= 1'b1;
                end else begin
                    sh  <= {sh[W-3:0], push_bit};
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcd_color_packer.sv
module lcd_color_packer
    import lcd_color_packer_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VW      = 4,
    parameter int NIB     = 4,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pix_valid,
    output logic           pix_ready,
    input  logic [7:0]     pix_idx,
    input  logic [1:0]     bpp_sel,
    input  logic           color_mode,
    input  logic           wide_bus,
    input  logic [VW-1:0]  frame_phase,
    input  logic           pal_we,
    input  logic [1:0]     pal_sel,
    input  logic [AW-1:0]  pal_addr,
    input  logic [VW-1:0]  pal_data,
    output logic [NIB-1:0] ud,
    output logic [NIB-1:0] ld,
    output logic           shift_en
);
    logic [NUM_CH-1:0][AW-1:0] raddr;
    logic [NUM_CH-1:0][VW-1:0] rdata;
    logic                      push, push_bit;

    pal_bank #(.ENTRIES(ENTRIES), .VW(VW), .NCH(NUM_CH)) u_pal (
        .clk(clk), .rst(rst), .we(pal_we), .sel(pal_sel),
        .waddr(pal_addr), .wdata(pal_data), .raddr(raddr), .rdata(rdata)
    );

    subpix_fsm #(.VW(VW), .AW(AW)) u_fsm (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_idx(pix_idx), .bpp_sel(bpp_sel), .color_mode(color_mode),
        .frame_phase(frame_phase), .raddr(raddr), .rdata(rdata),
        .push(push), .push_bit(push_bit)
    );

    bit_packer #(.NIB(NIB)) u_pack (
        .clk(clk), .rst(rst), .push(push), .push_bit(push_bit),
        .wide(wide_bus), .ud(ud), .ld(ld), .shift_en(shift_en)
    );
endmodule

// File: rtl/lcd_color_packer_chk.sv
module lcd_color_packer_chk #(
    parameter int NIB = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           pix_valid,
    input logic           pix_ready,
    input logic [1:0]     bpp_sel,
    input logic           color_mode,
    input logic           wide_bus,
    input logic [NIB-1:0] ud,
    input logic [NIB-1:0] ld,
    input logic           shift_en
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pix_ready && !shift_en && ud == '0 && ld == '0));

    p_lower_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !$past(wide_bus)) |-> (ld == '0));

    p_ready_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_ready && color_mode && bpp_sel != 2'd0) |=> !pix_ready);

    p_single_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> !shift_en);

    p_hold_data_r11: assert property (@(posedge clk) disable iff (rst)
        !shift_en |-> ($stable(ud) && $stable(ld)));
endmodule

bind lcd_color_packer lcd_color_packer_chk #(.NIB(NIB)) u_chk (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .bpp_sel(bpp_sel), .color_mode(color_mode), .wide_bus(wide_bus),
    .ud(ud), .ld(ld), .shift_en(shift_en)
);

// File: tb/lcd_color_packer_tb.sv
module lcd_color_packer_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       pix_valid;
    logic       pix_ready;
    logic [7:0] pix_idx;
    logic [1:0] bpp_sel;
    logic       color_mode;
    logic       wide_bus;
    logic [3:0] frame_phase;
    logic       pal_we;
    logic [1:0] pal_sel;
    logic [3:0] pal_addr;
    logic [3:0] pal_data;
    logic [3:0] ud;
    logic [3:0] ld;
    logic       shift_en;

    int checks = 0;
    int errors = 0;
    int ncap   = 0;
    logic [7:0] caps [16];

    always #10 clk = ~clk;

    lcd_color_packer u_dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_idx(pix_idx), .bpp_sel(bpp_sel), .color_mode(color_mode),
        .wide_bus(wide_bus), .frame_phase(frame_phase), .pal_we(pal_we),
        .pal_sel(pal_sel), .pal_addr(pal_addr), .pal_data(pal_data),
        .ud(ud), .ld(ld), .shift_en(shift_en)
    );

    // Word capture monitor
    always @(negedge clk) begin
        if (!rst && shift_en) begin
            if (ncap < 16) caps[ncap] = {ud, ld};
            ncap = ncap + 1;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pix_valid = 1'b0; pix_idx = '0; pal_we = 1'b0;
        pal_sel = '0; pal_addr = '0; pal_data = '0; frame_phase = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ncap = 0;
    endtask

    task automatic send(logic [7:0] idx);
        pix_idx = idx;
        pix_valid = 1'b1;
        while (!pix_ready) @(negedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic wr_pal(logic [1:0] s, logic [3:0] a, logic [3:0] d);
        pal_we = 1'b1; pal_sel = s; pal_addr = a; pal_data = d;
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic flush();
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        bpp_sel = 2'd0; color_mode = 1'b0; wide_bus = 1'b0;
        do_reset();
        check("R1 ud", ud, 0);
        check("R1 ld", ld, 0);
        check("R1 shift_en", shift_en, 0);
        check("R1 pix_ready", pix_ready, 1);
    endtask

    task automatic test_mono_narrow();
        bpp_sel = 2'd0; color_mode = 1'b1; wide_bus = 1'b0;
        do_reset();
        frame_phase = 4'hF;
        send(8'h01); send(8'hFE); send(8'h01);
        flush();
        check("R11 no early word", ncap, 0);
        send(8'h01);
        flush();
        check("R2 word count", ncap, 1);
        check("R2 R12 first word", caps[0], 8'hB0);
        check("R4 lower nibble", caps[0][3:0], 0);
        repeat (5) @(negedge clk);
        check("R11 hold ud", ud, 4'hB);
        send(8'h00); send(8'h01); send(8'h10); send(8'hF0);
        flush();
        check("R2 R12 second word", caps[1], 8'h40);
        check("R11 single strobe per word", ncap, 2);
    endtask

    task automatic test_mono_wide();
        bpp_sel = 2'd0; color_mode = 1'b0; wide_bus = 1'b1;
        do_reset();
        send(8'h01); send(8'h00); send(8'h00); send(8'h01);
        send(8'h01); send(8'h01); send(8'h00);
        flush();
        check("R3 no word before 8 bits", ncap, 0);
        send(8'h01);
        flush();
        check("R3 wide word", caps[0], 8'h9D);
    endtask

    task automatic test_color_narrow();
        bpp_sel = 2'd2; color_mode = 1'b1; wide_bus = 1'b0;
        do_reset();
        frame_phase = 4'd0;
        wr_pal(2'd0, 4'd1, 4'd1); wr_pal(2'd1, 4'd1, 4'd0); wr_pal(2'd2, 4'd1, 4'd1);
        wr_pal(2'd0, 4'd2, 4'd0); wr_pal(2'd1, 4'd2, 4'd3); wr_pal(2'd2, 4'd2, 4'd3);
        wr_pal(2'd0, 4'd3, 4'd4); wr_pal(2'd1, 4'd3, 4'd4); wr_pal(2'd2, 4'd3, 4'd0);
        send(8'hF1);
        check("R5 ready low after color accept", pix_ready, 0);
        @(negedge clk);
        check("R5 ready low second cycle", pix_ready, 0);
        send(8'h02); send(8'h03); send(8'h01);
        flush();
        check("R5 R10 word count", ncap, 3);
        check("R5 R7 R10 word 1", caps[0], 8'hA0);
        check("R5 R10 word 2", caps[1], 8'hF0);
        check("R5 R10 word 3", caps[2], 8'h50);
    endtask

    task automatic test_color_wide();
        bpp_sel = 2'd3; color_mode = 1'b1; wide_bus = 1'b1;
        do_reset();
        frame_phase = 4'd2;
        send(8'h66); send(8'h57); send(8'hE1);
        flush();
        check("R8 word count", ncap, 1);
        check("R8 R3 color byte", caps[0], 8'h8E);
    endtask

    task automatic test_gray();
        bpp_sel = 2'd1; color_mode = 1'b0; wide_bus = 1'b0;
        do_reset();
        frame_phase = 4'd5;
        wr_pal(2'd0, 4'd3, 4'd15);
        wr_pal(2'd1, 4'd1, 4'd12);
        send(8'h05); send(8'h0E); send(8'h03); send(8'h01);
        flush();
        check("R6 R7 gray 2bpp word", caps[0], 8'h90);
        bpp_sel = 2'd2;
        wr_pal(2'd3, 4'd6, 4'd0);
        send(8'hF6); send(8'h05); send(8'h01); send(8'h0F);
        flush();
        check("R9 R10 gray 4bpp word", caps[1], 8'hB0);
        check("R4 gray lower nibble", ld, 0);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; pix_valid = 1'b0; pix_idx = '0; bpp_sel = '0;
        color_mode = 1'b0; wide_bus = 1'b0; frame_phase = '0;
        pal_we = 1'b0; pal_sel = '0; pal_addr = '0; pal_data = '0;
        test_reset();
        test_mono_narrow();
        test_mono_wide();
        test_color_narrow();
        test_color_wide();
        test_gray();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule